// File: doc/BRIEF.md
# Adaptive Dead-Time Sequencer

This block sits between a PWM modulator and the two gate drivers of an active-clamp flyback stage. It takes level requests for the high-side (clamp) switch and the low-side (main) switch. From them it produces two gate commands that are never on together. It also inserts a dead time at each hand-over.

The dead time from high-side off to low-side on depends on the line. A minimum length applies at high line, and the interval grows linearly when the line-sense current code falls below a threshold. When that interval expires, the synchronized zero-crossing bit is sampled again. A transient dip is rejected, and the block waits for the next genuine rising edge of the zero-crossing bit before it turns the low side on.

The dead time from low-side off to high-side on follows the falling edge of the zero-crossing bit directly. A legacy mode selects either a fixed delay or that edge plus a fixed delay. A missing edge ends the cycle with a one-cycle timeout flag.

Top module: `deadtime_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `hs_gate`, `ls_gate` and `dt_timeout` are 0, and the sequencer is idle.
- R2: `hs_gate` and `ls_gate` are never 1 in the same cycle. Each gate rises only after the other gate has been low for at least one full cycle.
- R3: When idle, a sampled `ls_req`=1 raises `ls_gate` on the next cycle. Otherwise a sampled `hs_req`=1 raises `hs_gate` on the next cycle. An on gate drops one cycle after its request is sampled at 0.
- R4: When `line_code` >= LINE_TH (666), the high-to-low dead time is exactly `tz_min` cycles. This dead time counts both gates low, from the cycle after `hs_gate` falls up to the cycle in which `ls_gate` rises.
- R5: When `line_code` < LINE_TH, the high-to-low dead time is `tz_min + floor(tz_min*2*(LINE_TH-line_code)/(5*LINE_TH))` cycles. This is never more than 1.4 times `tz_min`. The value is taken from `line_code` on the cycle `hs_gate` is released.
- R6: If `zcd` is sampled 0 on the cycle the high-to-low dead time expires, `ls_gate` stays low. It rises one cycle after the next sampled 0-to-1 transition of `zcd`.
- R7: With `mode_enh`=1, `hs_gate` rises on the cycle right after the first sampled 1-to-0 transition of `zcd` that follows the `ls_gate` fall. This holds for either value of `set_sel`.
- R8: With `mode_enh`=0 and `set_sel`=0, both gates stay low for exactly LEG_CYC cycles (default 5, which is 40 ns at 125 MHz) between `ls_gate` falling and `hs_gate` rising.
- R9: With `mode_enh`=0 and `set_sel`=1, `hs_gate` rises LEG_CYC cycles after the cycle in which the 1-to-0 transition of `zcd` is sampled.
- R10: If no 1-to-0 transition of `zcd` is sampled within TMO_CYC cycles after `ls_gate` falls, `hs_gate` is not raised for that cycle. In that case `dt_timeout` is 1 for exactly one cycle and the sequencer returns to idle.
- R11: A `hs_req` that rises while a dead time is counting neither raises `hs_gate` nor shortens the interval.
- R12: If the request for the gate about to be turned on is 0 when its dead time ends, both gates stay low and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_req | input | 1 | High-side request from the modulator |
| ls_req | input | 1 | Low-side request from the modulator |
| zcd | input | 1 | Synchronized switch-node zero-crossing bit |
| line_code | input | LS_W | Line-sense current code |
| tz_min | input | TZ_W | Minimum high-to-low dead time, in cycles |
| mode_enh | input | 1 | 1: enhanced edge-driven mode, 0: legacy mode |
| set_sel | input | 1 | Legacy variant select |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| dt_timeout | output | 1 | One-cycle pulse on a missing zero-crossing fall |

## Verification
The assertions assume that `zcd` is already synchronized to `clk` and that `tz_min` is at least 1. They also assume that the mode inputs, `tz_min` and `line_code` stay constant while one switching period is in progress. The stimulus changes these settings only between periods, while the sequencer is idle or a gate is on. It also drives every input on the falling clock edge, so each rising edge sees stable values, including the dip, the late-edge and the missing-edge patterns of `zcd`.

// File: rtl/deadtime_seq.sv
module deadtime_seq #(
  parameter int LS_W    = 10,
  parameter int TZ_W    = 8,
  parameter int CNT_W   = 12,
  parameter int LINE_TH = 666,
  parameter int LEG_CYC = 5,
  parameter int TMO_CYC = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_req,
  input  logic            ls_req,
  input  logic            zcd,
  input  logic [LS_W-1:0] line_code,
  input  logic [TZ_W-1:0] tz_min,
  input  logic            mode_enh,
  input  logic            set_sel,
  output logic            hs_gate,
  output logic            ls_gate,
  output logic            dt_timeout
);

  localparam logic [31:0]      TH32  = 32'(LINE_TH);
  localparam logic [CNT_W-1:0] LEG_C = CNT_W'(LEG_CYC);
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TMO_CYC);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_HS, S_TZ, S_WRISE, S_LS, S_WFALL, S_LEG
  } st_t;

  st_t              st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n, tgt, tgt_n;
  logic             zcd_d, tmo_n;
  logic [31:0]      code32, short32, ext32;

  wire zr = zcd & ~zcd_d;
  wire zf = ~zcd & zcd_d;

  assign code32  = 32'(line_code);
  assign short32 = (code32 < TH32) ? (TH32 - code32) : 32'd0;
  assign ext32   = (32'(tz_min) * short32 * 32'd2) / (TH32 * 32'd5);

  always_comb begin
    st_n  = st;
    cnt_n = cnt + ONE_C;
    tgt_n = tgt;
    tmo_n = 1'b0;
    unique case (st)
      S_IDLE:
        if (ls_req)      st_n = S_LS;
        else if (hs_req) st_n = S_HS;
      S_HS:
        if (!hs_req) begin
          st_n  = S_TZ;
          cnt_n = ONE_C;
          tgt_n = CNT_W'(32'(tz_min) + ext32);
        end
      S_TZ:
        if (cnt >= tgt) begin
          if (!zcd)        st_n = S_WRISE;
          else if (ls_req) st_n = S_LS;
          else             st_n = S_IDLE;
        end
      S_WRISE:
        if (!ls_req) st_n = S_IDLE;
        else if (zr) st_n = S_LS;
      S_LS:
        if (!ls_req) begin
          st_n  = S_WFALL;
          cnt_n = ONE_C;
        end
      S_WFALL:
        if (!mode_enh && !set_sel) begin
          if (cnt >= LEG_C) st_n = hs_req ? S_HS : S_IDLE;
        end else if (zf) begin
          if (mode_enh) st_n = hs_req ? S_HS : S_IDLE;
          else begin
            st_n  = S_LEG;
            cnt_n = ONE_C;
          end
        end else if (cnt >= TMO_C) begin
          st_n  = S_IDLE;
          tmo_n = 1'b1;
        end
      S_LEG:
        if (cnt >= LEG_C) st_n = hs_req ? S_HS : S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      tgt        <= '0;
      zcd_d      <= 1'b0;
      hs_gate    <= 1'b0;
      ls_gate    <= 1'b0;
      dt_timeout <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      tgt        <= tgt_n;
      zcd_d      <= zcd;
      hs_gate    <= (st_n == S_HS);
      ls_gate    <= (st_n == S_LS);
      dt_timeout <= tmo_n;
    end
  end

endmodule

module deadtime_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_req,
  input logic ls_req,
  input logic hs_gate,
  input logic ls_gate,
  input logic dt_timeout
);

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R2
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> !$past(hs_gate));

  // R2
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> !$past(ls_gate));

  // R3
  hs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(hs_req));

  // R12
  ls_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(ls_req));

  // R10
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_timeout |=> !dt_timeout);

  // R10
  tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_timeout |-> (!hs_gate && !ls_gate));

endmodule

bind deadtime_seq deadtime_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .dt_timeout(dt_timeout)
);

// File: tb/deadtime_seq_tb.sv
`timescale 1ns/1ps
module deadtime_seq_tb;
  localparam int TH  = 666;
  localparam int LEG = 5;
  localparam int TMO = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hs_req = 0, ls_req = 0, zcd = 0, mode_enh = 1, set_sel = 0;
  logic [9:0] line_code = 10'd700;
  logic [7:0] tz_min = 8'd6;
  logic hs_gate, ls_gate, dt_timeout;

  int vecs = 0, errs = 0, cyc = 0;

  always #4 clk = ~clk;

  deadtime_seq u_dut (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req), .zcd(zcd),
    .line_code(line_code), .tz_min(tz_min), .mode_enh(mode_enh),
    .set_sel(set_sel), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .dt_timeout(dt_timeout)
  );

  // behavioural reference: phase 0 idle,1 high,2 tz,3 wait rise,4 low,5 wait fall,6 legacy delay
  int ph = 0, n = 0, goal = 0;
  bit zprev = 0, m_hs = 0, m_ls = 0, m_to = 0;
  string tag = "R1";

  function automatic int tz_len(int tmin, int code);
    if (code >= TH) return tmin;
    return tmin + (tmin * 2 * (TH - code)) / (5 * TH);
  endfunction

  always @(posedge clk) begin
    bit up, dn;
    up = zcd && !zprev;
    dn = !zcd && zprev;
    m_to = 0;
    if (!rst_n) begin
      ph = 0; zprev = 0; tag = "R1";
    end else begin
      case (ph)
        0: begin tag = "R3"; if (ls_req) ph = 4; else if (hs_req) ph = 1; end
        1: if (!hs_req) begin
             ph = 2; n = 1; goal = tz_len(int'(tz_min), int'(line_code));
             tag = (int'(line_code) >= TH) ? "R4" : "R5";
           end
        2: begin
             if (hs_req) tag = "R11";
             if (n >= goal) begin
               if (!zcd) begin ph = 3; tag = "R6"; end
               else if (ls_req) ph = 4;
               else begin ph = 0; tag = "R12"; end
             end else n++;
           end
        3: if (!ls_req) begin ph = 0; tag = "R12"; end
           else if (up) ph = 4;
        4: begin tag = "R3"; if (!ls_req) begin ph = 5; n = 1; end end
        5: begin
             tag = mode_enh ? "R7" : (set_sel ? "R9" : "R8");
             if (!mode_enh && !set_sel) begin
               if (n >= LEG) ph = hs_req ? 1 : 0; else n++;
             end else if (dn) begin
               if (mode_enh) ph = hs_req ? 1 : 0;
               else begin ph = 6; n = 1; end
             end else if (n >= TMO) begin
               ph = 0; m_to = 1; tag = "R10";
             end else n++;
           end
        6: if (n >= LEG) ph = hs_req ? 1 : 0; else n++;
        default: ph = 0;
      endcase
      zprev = zcd;
    end
    m_hs = (ph == 1) && rst_n;
    m_ls = (ph == 4) && rst_n;
    if (!rst_n) begin m_hs = 0; m_ls = 0; end
  end

  always @(negedge clk) begin
    cyc++;
    vecs++;
    if (hs_gate !== m_hs || ls_gate !== m_ls || dt_timeout !== m_to) begin
      errs++;
      $display("FAIL %s cycle %0d: hs/ls/to = %b%b%b expected %b%b%b", tag, cyc,
               hs_gate, ls_gate, dt_timeout, m_hs, m_ls, m_to);
    end
    if (hs_gate && ls_gate) begin
      errs++;
      $display("FAIL R2 cycle %0d: both gates on, actual 11 expected not 11", cyc);
    end
  end

  task automatic wait_cyc(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // one switching period: high side, tz, low side, low-to-high dead time
  task automatic period(int tmin, int code, bit enh, bit sel, bit dip,
                        bit hs_poke, bit ls_drop, int fall_at, bit no_fall);
    int g;
    g = tz_len(tmin, code);
    @(negedge clk);
    tz_min = 8'(tmin); line_code = 10'(code); mode_enh = enh; set_sel = sel;
    hs_req = 1; ls_req = 0; zcd = 0;
    wait_cyc(4);
    hs_req = 0; ls_req = !ls_drop; zcd = 1;
    if (dip) begin
      wait_cyc(1); zcd = 0;
      wait_cyc(g + 3); zcd = 1;
    end
    if (hs_poke) begin wait_cyc(1); hs_req = 1; wait_cyc(1); hs_req = 0; end
    wait_cyc(g + 4);
    ls_req = 1;
    wait_cyc(5);
    ls_req = 0; hs_req = 1;
    if (no_fall) wait_cyc(TMO + 6);
    else begin
      wait_cyc(fall_at); zcd = 0;
      wait_cyc(LEG + 4);
    end
    hs_req = 0;
    wait_cyc(g + 3);
    ls_req = 0;
    wait_cyc(3);
  endtask

  initial begin
    rst_n = 0;
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(2);
    // R3: both requests high in idle, low side wins
    hs_req = 1; ls_req = 1; wait_cyc(3); ls_req = 0; wait_cyc(4);
    hs_req = 0; wait_cyc(10);
    // R4 / R7
    period(6, 700, 1, 0, 0, 0, 0, 3, 0);
    period(1, 666, 1, 1, 0, 0, 0, 1, 0);
    // R5 at several codes
    period(20, 665, 1, 0, 0, 0, 0, 2, 0);
    period(20, 333, 1, 0, 0, 0, 0, 2, 0);
    period(255, 0, 1, 0, 0, 0, 0, 4, 0);
    // R6 dip rejection
    period(8, 500, 1, 0, 1, 0, 0, 3, 0);
    // R8 and R9 legacy
    period(6, 800, 0, 0, 0, 0, 0, 2, 0);
    period(6, 800, 0, 1, 0, 0, 0, 3, 0);
    // R10 missing fall, enhanced and legacy-edge
    period(6, 800, 1, 0, 0, 0, 0, 0, 1);
    period(6, 800, 0, 1, 0, 0, 0, 0, 1);
    // R11 high-side request during tz
    period(10, 700, 1, 0, 0, 1, 0, 2, 0);
    // R12 low-side request absent at expiry
    period(6, 700, 1, 0, 0, 0, 1, 2, 0);
    // R1 reset mid-period
    hs_req = 1; wait_cyc(3); rst_n = 0; wait_cyc(2); hs_req = 0; rst_n = 1; wait_cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule